// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Address Filtering

This block turns a single asynchronous serial line into characters of 7, 8 or 9 bits, with an optional even or odd parity bit, using a 16x oversampling tick from an external rate generator. Each finished character lands in a two-part holding buffer: a low byte and a high register whose bit 0 carries character bit 8. The low byte is read last, and reading it clears the buffer-full flag.

The receiver tracks parity, framing and overrun errors, along with a combined error flag. It emits one-cycle request pulses for "buffer holds a clean character" and "an error occurred". Reading the status register clears the error flags.

An address-filter mode supports multidrop links. In this mode a character whose top bit is clear is stored without a buffer-full request. After the first character, later characters overwrite the buffer without raising overrun, so software only wakes on address characters.

Top module: `uart_addr_rx`

## Requirements
- R1: A parity, framing or overrun error sets its own flag and the combined error flag (`serr_o`), and pulses `irq_err_o` for one cycle in the cycle `char_done_o` pulses.
- R2: A character finished with any error never pulses `irq_full_o`.
- R3: `rx_en_i` is looked at only while the line is idle. Clearing it after a start bit has been accepted still delivers that character in full. While it is low, no new character is started.
- R4: Every stored character sets `buf_full_o`. Only a low-byte read (`rd_lo_i`), an initialisation or reset clears it. A low-byte read in the same cycle a character finishes counts as emptying the buffer first: the new character is stored, with no overrun, and `buf_full_o` reads 1 in that cycle.
- R5: `len_i` encodes 00 = 7 bits, 01 = 8 bits, 10 = 9 bits. Bits are received LSB first. A 7-bit character stores bit 7 of `lo_q_o` as 0 and `hi_q_o` as 0. An 8-bit character stores `hi_q_o` as 0. A 9-bit character stores bit 8 in `hi_q_o[0]`, with `hi_q_o[7:1]` zero.
- R6: Error flags clear on a status read (`rd_stat_i`), on `init_i` and on reset. A new error in the same cycle as a status read leaves its flags set.
- R7: In address mode, a stored character whose top bit (bit 7 for 8-bit, bit 8 for 9-bit) is 0 sets `buf_full_o` but does not pulse `irq_full_o`. A clean character with that bit at 1 does pulse it.
- R8: In address mode, once one character has finished since `init_i`, later characters never flag overrun and replace the buffer contents.
- R9: Address mode with 7-bit length, or `len_i` = 11, drives `cfg_bad_o` high. No new character is started while it is high.
- R10: Outside address mode, a character that finishes while `buf_full_o` is set and no low-byte read is present sets the overrun flag and leaves `lo_q_o`/`hi_q_o` unchanged.
- R11: When `par_en_i` is set, one parity bit follows the data (even when `par_odd_i` = 0, odd when 1) and a mismatch sets `perr_o`. A stop bit sampled low sets `ferr_o`.
- R12: `char_done_o` pulses once per finished character, in the same cycle that the buffer, flags and request pulses show its result. Nothing pulses when no character finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, idle high |
| tick16_i | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_en_i | input | 1 | Allows new characters to start |
| init_i | input | 1 | Receiver initialisation: clears flags, buffer-full and the address-mode first-character state |
| len_i | input | 2 | Character length code (see R5) |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | Odd parity when 1 |
| addr_mode_i | input | 1 | Address-filter mode |
| rd_lo_i | input | 1 | Low-byte read strobe |
| rd_stat_i | input | 1 | Status read strobe |
| lo_q_o | output | 8 | Low buffer byte |
| hi_q_o | output | 8 | High buffer register (bit 0 = character bit 8) |
| buf_full_o | output | 1 | Buffer-full flag |
| perr_o | output | 1 | Parity error flag |
| ferr_o | output | 1 | Framing error flag |
| oerr_o | output | 1 | Overrun error flag |
| serr_o | output | 1 | Combined error flag |
| irq_full_o | output | 1 | Buffer-full request pulse |
| irq_err_o | output | 1 | Error request pulse |
| char_done_o | output | 1 | Character-finished pulse |
| cfg_bad_o | output | 1 | Invalid configuration |

## Verification
Two pairs of events can land in the same clock edge. The first is a low-byte read with a character completing. The second is a status read with an error being set. The bench provokes each pair by holding `rd_lo_i` or `rd_stat_i` high across a whole frame, so the read is certainly present in the completion cycle. At `char_done_o` it expects the new character stored with `buf_full_o` = 1 and no overrun, or the error flags set. Once the strobe is released it expects those flags cleared.

// File: rtl/uart_addr_rx_pkg.sv
package uart_addr_rx_pkg;

  localparam int unsigned CHAR_MAX = 9;

  typedef enum logic [1:0] {
    LEN7 = 2'b00,
    LEN8 = 2'b01,
    LEN9 = 2'b10,
    LENX = 2'b11
  } len_e;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP
  } rx_st_e;

  // index of the last data bit for a length code
  function automatic logic [3:0] last_bit(input logic [1:0] len);
    case (len)
      LEN7:    return 4'd6;
      LEN9:    return 4'd8;
      default: return 4'd7;
    endcase
  endfunction

  // shift register fills from the top; move the character down to bit 0
  function automatic logic [CHAR_MAX-1:0] align_char(input logic [CHAR_MAX-1:0] sh,
                                                     input logic [1:0] len);
    case (len)
      LEN7:    return {2'b00, sh[CHAR_MAX-1:2]};
      LEN9:    return sh;
      default: return {1'b0, sh[CHAR_MAX-1:1]};
    endcase
  endfunction

  function automatic logic parity_bad(input logic [CHAR_MAX-1:0] d,
                                      input logic pbit, input logic odd);
    return ((^d) ^ pbit) != odd;
  endfunction

  function automatic logic top_bit(input logic [CHAR_MAX-1:0] d, input logic [1:0] len);
    return (len == LEN9) ? d[8] : d[7];
  endfunction

  function automatic logic [7:0] low_part(input logic [CHAR_MAX-1:0] d, input logic [1:0] len);
    return (len == LEN7) ? {1'b0, d[6:0]} : d[7:0];
  endfunction

  function automatic logic [7:0] high_part(input logic [CHAR_MAX-1:0] d, input logic [1:0] len);
    return (len == LEN9) ? {7'd0, d[8]} : 8'd0;
  endfunction

endpackage

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_addr_rx_pkg::*;
#(
  parameter int unsigned OVS         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                init_i,
  input  logic                tick_i,
  input  logic                rx_i,
  input  logic                start_ok_i,
  input  logic [1:0]          len_i,
  input  logic                par_en_i,
  input  logic                par_odd_i,
  output logic                done_o,
  output logic [CHAR_MAX-1:0] data_o,
  output logic                perr_o,
  output logic                ferr_o
);

  localparam int unsigned CW = $clog2(OVS);
  localparam logic [CW-1:0] HALF = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] FULL = CW'(OVS - 1);

  logic rxs;

  generate
    if (SYNC_STAGES < 2) begin : g_sync1
      logic r1;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) r1 <= 1'b1;
        else        r1 <= rx_i;
      assign rxs = r1;
    end else begin : g_syncn
      logic [SYNC_STAGES-1:0] sr;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sr <= '1;
        else        sr <= {sr[SYNC_STAGES-2:0], rx_i};
      assign rxs = sr[SYNC_STAGES-1];
    end
  endgenerate

  rx_st_e              st;
  logic [CW-1:0]       cnt;
  logic [3:0]          idx;
  logic [CHAR_MAX-1:0] sh;
  logic                pbit;
  logic [CHAR_MAX-1:0] char_now;

  assign char_now = align_char(sh, len_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      idx    <= '0;
      sh     <= '0;
      pbit   <= 1'b0;
      done_o <= 1'b0;
      data_o <= '0;
      perr_o <= 1'b0;
      ferr_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (init_i) begin
        st <= S_IDLE;
      end else if (tick_i) begin
        case (st)
          S_IDLE: if (start_ok_i && !rxs) begin
            st  <= S_START;
            cnt <= '0;
          end
          S_START: if (cnt == HALF) begin
            cnt <= '0;
            idx <= '0;
            st  <= rxs ? S_IDLE : S_DATA;
          end else cnt <= cnt + 1'b1;
          S_DATA: if (cnt == FULL) begin
            cnt <= '0;
            sh  <= {rxs, sh[CHAR_MAX-1:1]};
            idx <= idx + 1'b1;
            if (idx == last_bit(len_i)) st <= par_en_i ? S_PAR : S_STOP;
          end else cnt <= cnt + 1'b1;
          S_PAR: if (cnt == FULL) begin
            cnt  <= '0;
            pbit <= rxs;
            st   <= S_STOP;
          end else cnt <= cnt + 1'b1;
          S_STOP: if (cnt == FULL) begin
            cnt    <= '0;
            st     <= S_IDLE;
            done_o <= 1'b1;
            data_o <= char_now;
            ferr_o <= !rxs;
            perr_o <= par_en_i && parity_bad(char_now, pbit, par_odd_i);
          end else cnt <= cnt + 1'b1;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/uart_rx_store.sv
module uart_rx_store
  import uart_addr_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                init_i,
  input  logic                done_i,
  input  logic [CHAR_MAX-1:0] data_i,
  input  logic                perr_i,
  input  logic                ferr_i,
  input  logic [1:0]          len_i,
  input  logic                addr_mode_i,
  input  logic                rd_lo_i,
  input  logic                rd_stat_i,
  output logic [7:0]          lo_q_o,
  output logic [7:0]          hi_q_o,
  output logic                buf_full_o,
  output logic                perr_o,
  output logic                ferr_o,
  output logic                oerr_o,
  output logic                serr_o,
  output logic                irq_full_o,
  output logic                irq_err_o,
  output logic                char_done_o,
  output logic                err_evt_o
);

  logic seen_first;
  logic room, ovr_evt, load_evt, full_evt;

  assign room      = !buf_full_o || rd_lo_i;
  assign ovr_evt   = done_i && !room && !(addr_mode_i && seen_first);
  assign err_evt_o = done_i && (perr_i || ferr_i || ovr_evt);
  assign load_evt  = done_i && !ovr_evt;
  assign full_evt  = load_evt && !perr_i && !ferr_i &&
                     !(addr_mode_i && !top_bit(data_i, len_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q_o      <= '0;
      hi_q_o      <= '0;
      buf_full_o  <= 1'b0;
      perr_o      <= 1'b0;
      ferr_o      <= 1'b0;
      oerr_o      <= 1'b0;
      serr_o      <= 1'b0;
      irq_full_o  <= 1'b0;
      irq_err_o   <= 1'b0;
      char_done_o <= 1'b0;
      seen_first  <= 1'b0;
    end else if (init_i) begin
      buf_full_o  <= 1'b0;
      perr_o      <= 1'b0;
      ferr_o      <= 1'b0;
      oerr_o      <= 1'b0;
      serr_o      <= 1'b0;
      irq_full_o  <= 1'b0;
      irq_err_o   <= 1'b0;
      char_done_o <= 1'b0;
      seen_first  <= 1'b0;
    end else begin
      char_done_o <= done_i;
      irq_full_o  <= full_evt;
      irq_err_o   <= err_evt_o;
      if (load_evt) begin
        lo_q_o     <= low_part(data_i, len_i);
        hi_q_o     <= high_part(data_i, len_i);
        buf_full_o <= 1'b1;
      end else if (rd_lo_i) begin
        buf_full_o <= 1'b0;
      end
      seen_first <= addr_mode_i && (seen_first || done_i);
      perr_o <= (perr_o && !rd_stat_i) || (done_i && perr_i);
      ferr_o <= (ferr_o && !rd_stat_i) || (done_i && ferr_i);
      oerr_o <= (oerr_o && !rd_stat_i) || ovr_evt;
      serr_o <= (serr_o && !rd_stat_i) || err_evt_o;
    end
  end

endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx
  import uart_addr_rx_pkg::*;
#(
  parameter int unsigned OVS         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_i,
  input  logic       tick16_i,
  input  logic       rx_en_i,
  input  logic       init_i,
  input  logic [1:0] len_i,
  input  logic       par_en_i,
  input  logic       par_odd_i,
  input  logic       addr_mode_i,
  input  logic       rd_lo_i,
  input  logic       rd_stat_i,
  output logic [7:0] lo_q_o,
  output logic [7:0] hi_q_o,
  output logic       buf_full_o,
  output logic       perr_o,
  output logic       ferr_o,
  output logic       oerr_o,
  output logic       serr_o,
  output logic       irq_full_o,
  output logic       irq_err_o,
  output logic       char_done_o,
  output logic       cfg_bad_o
);

  logic                start_ok;
  logic                frm_done;
  logic [CHAR_MAX-1:0] frm_data;
  logic                frm_perr, frm_ferr;
  logic                err_evt;

  assign cfg_bad_o = (len_i == LENX) || (addr_mode_i && len_i == LEN7);
  assign start_ok  = rx_en_i && !cfg_bad_o;

  uart_rx_frame #(.OVS(OVS), .SYNC_STAGES(SYNC_STAGES)) u_frame (
    .clk(clk), .rst_n(rst_n), .init_i(init_i), .tick_i(tick16_i), .rx_i(rx_i),
    .start_ok_i(start_ok), .len_i(len_i), .par_en_i(par_en_i), .par_odd_i(par_odd_i),
    .done_o(frm_done), .data_o(frm_data), .perr_o(frm_perr), .ferr_o(frm_ferr)
  );

  uart_rx_store u_store (
    .clk(clk), .rst_n(rst_n), .init_i(init_i), .done_i(frm_done), .data_i(frm_data),
    .perr_i(frm_perr), .ferr_i(frm_ferr), .len_i(len_i), .addr_mode_i(addr_mode_i),
    .rd_lo_i(rd_lo_i), .rd_stat_i(rd_stat_i), .lo_q_o(lo_q_o), .hi_q_o(hi_q_o),
    .buf_full_o(buf_full_o), .perr_o(perr_o), .ferr_o(ferr_o), .oerr_o(oerr_o),
    .serr_o(serr_o), .irq_full_o(irq_full_o), .irq_err_o(irq_err_o),
    .char_done_o(char_done_o), .err_evt_o(err_evt)
  );

endmodule

// File: rtl/uart_addr_rx_chk.sv
module uart_addr_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       init_i,
  input logic       rd_lo_i,
  input logic       rd_stat_i,
  input logic [7:0] hi_q_o,
  input logic       buf_full_o,
  input logic       perr_o,
  input logic       ferr_o,
  input logic       oerr_o,
  input logic       serr_o,
  input logic       irq_full_o,
  input logic       irq_err_o,
  input logic       char_done_o,
  input logic       err_evt
);

  assert_err_sums_R1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err_o |-> serr_o);

  assert_flags_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_o || ferr_o || oerr_o) |-> serr_o);

  assert_no_full_on_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err_o |-> !irq_full_o);

  assert_full_clear_by_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(buf_full_o) |-> $past(rd_lo_i || init_i));

  assert_hi_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hi_q_o[7:1] == 7'd0);

  assert_stat_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat_i && !err_evt) |=> !serr_o);

  assert_req_with_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_full_o || irq_err_o) |-> (char_done_o && (irq_err_o || buf_full_o)));

endmodule

bind uart_addr_rx uart_addr_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .init_i(init_i), .rd_lo_i(rd_lo_i), .rd_stat_i(rd_stat_i),
  .hi_q_o(hi_q_o), .buf_full_o(buf_full_o), .perr_o(perr_o), .ferr_o(ferr_o),
  .oerr_o(oerr_o), .serr_o(serr_o), .irq_full_o(irq_full_o), .irq_err_o(irq_err_o),
  .char_done_o(char_done_o), .err_evt(err_evt)
);

// File: tb/uart_addr_rx_tb.sv
module uart_addr_rx_tb;

  localparam int BIT_CLK = 64; // 16 ticks of 4 clocks

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0, rx_i = 1'b1, tick16_i = 1'b0, rx_en_i = 1'b1, init_i = 1'b0;
  logic [1:0] len_i = 2'b01;
  logic       par_en_i = 1'b0, par_odd_i = 1'b0, addr_mode_i = 1'b0;
  logic       rd_lo_i = 1'b0, rd_stat_i = 1'b0;
  logic [7:0] lo_q_o, hi_q_o;
  logic       buf_full_o, perr_o, ferr_o, oerr_o, serr_o;
  logic       irq_full_o, irq_err_o, char_done_o, cfg_bad_o;

  uart_addr_rx u_dut (.*);

  typedef struct {
    logic [22:0] v;
    string       req;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_err = 0, n_done = 0;
  bit   finished = 0;

  // bench model of the visible state
  logic [7:0] m_lo = 0, m_hi = 0;
  logic m_full = 0, m_pe = 0, m_fe = 0, m_oe = 0, m_se = 0, m_seen = 0;

  task automatic finish_run();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial forever begin
    repeat (3) @(posedge clk);
    #1 tick16_i = 1'b1;
    @(posedge clk);
    #1 tick16_i = 1'b0;
  end

  // monitor: compare each finished character against the scoreboard
  exp_t got;
  always @(negedge clk) begin
    if (rst_n && char_done_o === 1'b1) begin
      n_done++;
      if (q.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL R12 unexpected char_done actual=1 expected=0");
      end else begin
        got = q.pop_front();
        check(got.req, {9'd0, lo_q_o, hi_q_o, buf_full_o, perr_o, ferr_o, oerr_o,
                        serr_o, irq_full_o, irq_err_o}, {9'd0, got.v});
      end
    end
  end

  task automatic expect_char(logic [8:0] d, int nb, bit badpar, bit badstop,
                             bit rd_held, bit stat_held, string req);
    logic pe_n, fe_n, ov, err, msb, irf;
    exp_t e;
    pe_n = par_en_i && badpar;
    fe_n = badstop;
    ov   = m_full && !rd_held && !(addr_mode_i && m_seen);
    err  = pe_n || fe_n || ov;
    if (!ov) begin
      m_lo   = (nb == 7) ? {1'b0, d[6:0]} : d[7:0];
      m_hi   = (nb == 9) ? {7'd0, d[8]} : 8'd0;
      m_full = 1'b1;
    end
    msb = (nb == 9) ? d[8] : d[7];
    irf = !err && !(addr_mode_i && !msb);
    if (stat_held) begin m_pe = 0; m_fe = 0; m_oe = 0; m_se = 0; end
    m_pe = m_pe | pe_n;
    m_fe = m_fe | fe_n;
    m_oe = m_oe | ov;
    m_se = m_se | err;
    if (addr_mode_i) m_seen = 1'b1;
    e.v   = {m_lo, m_hi, m_full, m_pe, m_fe, m_oe, m_se, irf, err};
    e.req = req;
    q.push_back(e);
  endtask

  task automatic send_frame(logic [8:0] d, int nb, bit badpar, bit badstop);
    logic [8:0] dm;
    dm = d & 9'((1 << nb) - 1);
    rx_i = 1'b0; hold(BIT_CLK);
    for (int i = 0; i < nb; i++) begin rx_i = d[i]; hold(BIT_CLK); end
    if (par_en_i) begin rx_i = (^dm) ^ par_odd_i ^ badpar; hold(BIT_CLK); end
    if (badstop) begin rx_i = 1'b0; hold(48); rx_i = 1'b1; hold(16); end
    else begin rx_i = 1'b1; hold(BIT_CLK); end
    rx_i = 1'b1; hold(BIT_CLK);
  endtask

  task automatic xfer(logic [8:0] d, int nb, bit badpar, bit badstop, string req);
    expect_char(d, nb, badpar, badstop, 1'b0, 1'b0, req);
    send_frame(d, nb, badpar, badstop);
  endtask

  task automatic read_lo();
    rd_lo_i = 1'b1; hold(1); rd_lo_i = 1'b0; m_full = 0;
  endtask

  task automatic read_stat();
    rd_stat_i = 1'b1; hold(1); rd_stat_i = 1'b0;
    m_pe = 0; m_fe = 0; m_oe = 0; m_se = 0;
  endtask

  task automatic do_init();
    init_i = 1'b1; hold(1); init_i = 1'b0;
    m_full = 0; m_pe = 0; m_fe = 0; m_oe = 0; m_se = 0; m_seen = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL R12 watchdog actual=timeout expected=finish");
      finish_run();
    end
  end

  initial begin
    int nd;
    hold(5); rst_n = 1'b1; hold(5);
    check("R6 reset flags", {buf_full_o, perr_o, ferr_o, oerr_o, serr_o, irq_full_o, irq_err_o}, 0);
    check("R5 reset data", {lo_q_o, hi_q_o}, 0);
    check("R9 reset cfg ok", cfg_bad_o, 0);

    // 8-bit, no parity
    xfer(9'h0A5, 8, 0, 0, "R5 R12 8-bit char");
    read_lo();
    check("R4 low read clears full", buf_full_o, 0);

    // R10 overrun outside address mode
    xfer(9'h03C, 8, 0, 0, "R4 R12 char into empty");
    xfer(9'h077, 8, 0, 0, "R10 R1 R2 overrun keeps old");
    read_stat();
    check("R6 stat read clears errors", {perr_o, ferr_o, oerr_o, serr_o}, 0);
    check("R4 stat read keeps full", buf_full_o, 1);
    read_lo();

    // 9-bit even parity
    len_i = 2'b10; par_en_i = 1'b1; par_odd_i = 1'b0;
    xfer(9'h1C3, 9, 0, 0, "R5 R11 9-bit even parity");
    read_lo();
    xfer(9'h055, 9, 1, 0, "R11 R1 R2 parity error");
    read_lo(); read_stat();

    // 8-bit odd parity, high register goes back to 0
    len_i = 2'b01; par_odd_i = 1'b1;
    xfer(9'h081, 8, 0, 0, "R5 R11 8-bit odd parity");
    read_lo();
    par_en_i = 1'b0;

    // 7-bit
    len_i = 2'b00;
    xfer(9'h0FF, 7, 0, 0, "R5 7-bit bit7 zero");
    read_lo();
    len_i = 2'b01;

    // framing error
    xfer(9'h042, 8, 0, 1, "R11 R1 R2 framing error");
    read_lo(); read_stat();

    // collision: low read held across a completion
    xfer(9'h011, 8, 0, 0, "R4 fill buffer");
    expect_char(9'h022, 8, 0, 0, 1'b1, 1'b0, "R4 read same cycle as completion");
    rd_lo_i = 1'b1; send_frame(9'h022, 8, 0, 0); rd_lo_i = 1'b0; m_full = 0;
    check("R4 full cleared after held read", buf_full_o, 0);
    check("R10 no overrun on collision", oerr_o, 0);

    // collision: status read held across an error
    expect_char(9'h033, 8, 0, 1, 1'b0, 1'b1, "R6 error wins over status read");
    rd_stat_i = 1'b1; send_frame(9'h033, 8, 0, 1); rd_stat_i = 1'b0;
    m_pe = 0; m_fe = 0; m_oe = 0; m_se = 0;
    check("R6 flags cleared after held stat read", {ferr_o, serr_o}, 0);
    read_lo();

    // R3 enable dropped mid-character
    expect_char(9'h05A, 8, 0, 0, 1'b0, 1'b0, "R3 char finishes after disable");
    fork
      send_frame(9'h05A, 8, 0, 0);
      begin hold(100); rx_en_i = 1'b0; end
    join
    read_lo();
    nd = n_done;
    send_frame(9'h0C6, 8, 0, 0);
    check("R3 disabled receiver ignores line", n_done, nd);
    check("R3 buffer untouched while disabled", {buf_full_o, lo_q_o}, {1'b0, 8'h5A});
    rx_en_i = 1'b1;

    // address mode, 8-bit
    addr_mode_i = 1'b1; do_init();
    check("R6 init clears", {buf_full_o, serr_o}, 0);
    xfer(9'h085, 8, 0, 0, "R7 address char raises request");
    read_lo();
    xfer(9'h005, 8, 0, 0, "R7 data char no request");
    xfer(9'h006, 8, 0, 0, "R8 no overrun, overwrite");
    xfer(9'h090, 8, 0, 0, "R8 R7 overwrite with address char");
    check("R8 overrun never flagged", oerr_o, 0);

    // address mode, 9-bit
    len_i = 2'b10;
    xfer(9'h100, 9, 0, 0, "R7 9-bit address char");
    xfer(9'h0FF, 9, 0, 0, "R7 9-bit data char");
    read_lo();

    // R9 invalid configurations
    len_i = 2'b00; hold(1);
    check("R9 address plus 7-bit invalid", cfg_bad_o, 1);
    nd = n_done;
    send_frame(9'h0AA, 7, 0, 0);
    check("R9 no reception while invalid", n_done, nd);
    addr_mode_i = 1'b0; len_i = 2'b11; hold(1);
    check("R9 length code 11 invalid", cfg_bad_o, 1);
    len_i = 2'b01; hold(1);
    check("R9 valid again", cfg_bad_o, 0);

    // init clears error and full state
    xfer(9'h024, 8, 0, 1, "R11 framing before init");
    do_init();
    check("R6 init clears flags and full", {buf_full_o, perr_o, ferr_o, oerr_o, serr_o}, 0);

    hold(200);
    check("R12 every expected char seen", q.size(), 0);
    finish_run();
  end

endmodule